// File: doc/BRIEF.md
# Fixed-Length Program Sequencer

This block steps through a straight-line instruction store of 192 words. There are no branches. It keeps the fetch address and divides the input clock into instruction cycles of 16 clocks. It gives a one-clock strobe and a slow cycle clock whose falling edge opens each fetch cycle. A pass ends in one of two ways: the last word at address 191 has run, or an early restart is requested. An early restart comes either from a restart code in the 4-bit control field of the fetched word or from the active-low restart pin. Because fetch is four stages deep, a restart request is honoured only on an address that is a multiple of four. The counter then drains the next three instructions before it returns to zero.

The surrounding chip feeds back the control field of the word at `fetch_addr`. It uses `eop_pull` as the enable of an open-drain driver that pulls the shared restart pin low while a code-initiated restart is draining. `pass_done` marks the first clock of every new pass, so the sampling period equals the executed program length times 16 clocks. `align_err` is a sticky flag for misplaced restart requests.

Control is a three-state machine:
- `ST_RUN`: normal stepping.
- `ST_DRAIN_CODE`: draining after a restart code.
- `ST_DRAIN_PIN`: draining after a pin request.

The transitions, each taken on the last clock of an instruction cycle, are:
- `ST_RUN` to `ST_DRAIN_CODE` on an aligned restart code.
- `ST_RUN` to `ST_DRAIN_PIN` on an aligned pin request with no code present.
- Either drain state back to `ST_RUN` as the third drained instruction ends, which also forces the address to zero.
- Every other case holds the present state.

Top module: `prog_sequencer`

## Requirements
- R1: While `rst_n` is low, `fetch_addr` is 0, `fetch_strobe` is 1, and `cyc_clk`, `eop_pull`, `pass_done` and `align_err` are 0.
- R2: Each instruction cycle lasts 16 clocks. `fetch_strobe` is high in the first of them only, and `fetch_addr` changes only into a strobe clock.
- R3: After address 191 the next fetch address is 0, and the address after that is 1.
- R4: A restart code (control field value 4'hA) seen at an address A with A mod 4 = 0 gives the fetch sequence A+1, A+2, A+3, 0.
- R5: `eop_pull` is high in every clock of the three instruction cycles drained after a restart code, and low in all other clocks.
- R6: A restart code at an address not divisible by four has no effect on the fetch sequence. It sets `align_err`, which then stays set until `rst_n`.
- R7: `ext_rst_n` held low over the end of an instruction at an aligned address gives the same drain and return to 0 as R4, with `eop_pull` staying low. The pin passes through a two-stage synchroniser.
- R8: `ext_rst_n` low over the end of an instruction at an unaligned address has no effect on the fetch sequence and sets `align_err`.
- R9: `cyc_clk` is low for clocks 0 to 7 of each instruction cycle and high for clocks 8 to 15. Its falling edge coincides with `fetch_strobe`.
- R10: When a restart code and a pin request meet in the same aligned instruction, the code takes precedence and `eop_pull` is driven.
- R11: `pass_done` is high for exactly one clock per pass, namely the strobe clock of the address 0 reached by a wrap. It is not raised on the first pass after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous chip reset, active low |
| ext_rst_n | input | 1 | Shared restart pin as seen at the pad, active low |
| instr_ctrl | input | 4 | Control field of the word at `fetch_addr` |
| fetch_addr | output | 8 | Instruction store address, 0 to 191 |
| fetch_strobe | output | 1 | High in the first clock of each instruction cycle |
| cyc_clk | output | 1 | Input clock divided by 16, falling at each fetch start |
| eop_pull | output | 1 | Enable for the open-drain pull-down of the restart pin |
| pass_done | output | 1 | One-clock marker at the start of each new pass |
| align_err | output | 1 | Sticky misplaced-restart flag |

## Verification
Two functions can fall on the same instruction boundary.

The first case is a restart code at address 188. Its drain ends at 191, exactly where the natural end-of-store wrap also happens. The bench sweeps the code across every aligned address including 188. It then judges that address 0 appears once, that `pass_done` pulses once, and that the address after it is 1 rather than a second restart.

The second case is a restart code and a pin request in the same aligned instruction. The bench judges this by the drain length and by `eop_pull` being driven, which shows that the code was the cause taken.

// File: rtl/seq_pkg.sv
package seq_pkg;

    // Control states of the restart sequencing
    typedef enum logic [1:0] {
        ST_RUN        = 2'd0,
        ST_DRAIN_CODE = 2'd1,
        ST_DRAIN_PIN  = 2'd2
    } restart_state_e;

    // Restart causes seen in the current instruction
    typedef struct packed {
        logic code_hit;
        logic pin_req;
        logic aligned;
    } restart_cause_t;

endpackage

// File: rtl/seq_phase_gen.sv
module seq_phase_gen #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase_first,
    output logic phase_last,
    output logic cyc_clk
);
    localparam int CNT_W = $clog2(DIV);
    localparam int HALF  = DIV / 2;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_W'(DIV - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        phase_first = (cnt_q == '0);
        phase_last  = (cnt_q == CNT_W'(DIV - 1));
        cyc_clk     = rst_n && (cnt_q >= CNT_W'(HALF));
    end

endmodule

// File: rtl/seq_pin_sync.sv
module seq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic req
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= pin_n;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], pin_n};
            end
        end
    endgenerate

    assign req = ~chain_q[STAGES-1];

endmodule

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
#(
    parameter int                CTRL_W   = 4,
    parameter logic [CTRL_W-1:0] EOP_CODE = 4'hA,
    parameter int                ALIGN_B  = 2
) (
    input  logic [CTRL_W-1:0]  ctrl,
    input  logic [ALIGN_B-1:0] addr_low,
    input  logic               pin_req,
    output restart_cause_t     cause
);
    always_comb begin
        cause.code_hit = (ctrl == EOP_CODE);
        cause.pin_req  = pin_req;
        cause.aligned  = (addr_low == '0);
    end

endmodule

// File: rtl/seq_restart_fsm.sv
module seq_restart_fsm
    import seq_pkg::*;
#(
    parameter int PIPE = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    input  restart_cause_t cause,
    output logic           wrap_now,
    output logic           pull,
    output logic           err
);
    localparam int REM_W = $clog2(PIPE);

    restart_state_e   state_q, state_nx;
    logic [REM_W-1:0] rem_q, rem_nx;
    logic             err_q, err_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            rem_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_nx;
            rem_q   <= rem_nx;
            err_q   <= err_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state_q;
        rem_nx   = rem_q;
        err_nx   = err_q;
        if (step) begin
            unique case (state_q)
                ST_RUN: begin
                    if (cause.code_hit) begin
                        if (cause.aligned) begin
                            state_nx = ST_DRAIN_CODE;
                            rem_nx   = REM_W'(PIPE - 1);
                        end else begin
                            err_nx = 1'b1;
                        end
                    end else if (cause.pin_req) begin
                        if (cause.aligned) begin
                            state_nx = ST_DRAIN_PIN;
                            rem_nx   = REM_W'(PIPE - 1);
                        end else begin
                            err_nx = 1'b1;
                        end
                    end
                end
                ST_DRAIN_CODE, ST_DRAIN_PIN: begin
                    if (cause.code_hit && !cause.aligned) err_nx = 1'b1;
                    if (rem_q == REM_W'(1)) begin
                        state_nx = ST_RUN;
                        rem_nx   = '0;
                    end else begin
                        rem_nx = rem_q - 1'b1;
                    end
                end
                default: begin
                    state_nx = ST_RUN;
                    rem_nx   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        wrap_now = 1'b0;
        pull     = 1'b0;
        unique case (state_q)
            ST_RUN: ;
            ST_DRAIN_CODE: begin
                pull     = 1'b1;
                wrap_now = step && (rem_q == REM_W'(1));
            end
            ST_DRAIN_PIN: begin
                wrap_now = step && (rem_q == REM_W'(1));
            end
            default: ;
        endcase
        err = err_q;
    end

endmodule

// File: rtl/seq_addr_ctr.sv
module seq_addr_ctr #(
    parameter int DEPTH = 192
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step,
    input  logic                     wrap_req,
    output logic [$clog2(DEPTH)-1:0] addr,
    output logic                     pass_done
);
    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0] addr_q;
    logic          pass_q;
    logic          at_end;

    assign at_end = (addr_q == AW'(DEPTH - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            pass_q <= 1'b0;
        end else if (step) begin
            if (wrap_req || at_end) begin
                addr_q <= '0;
                pass_q <= 1'b1;
            end else begin
                addr_q <= addr_q + 1'b1;
                pass_q <= 1'b0;
            end
        end else begin
            pass_q <= 1'b0;
        end
    end

    assign addr      = addr_q;
    assign pass_done = pass_q;

endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer
    import seq_pkg::*;
#(
    parameter int                DEPTH       = 192,
    parameter int                DIV         = 16,
    parameter int                PIPE        = 4,
    parameter int                CTRL_W      = 4,
    parameter logic [CTRL_W-1:0] EOP_CODE    = 4'hA,
    parameter int                SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ext_rst_n,
    input  logic [CTRL_W-1:0]        instr_ctrl,
    output logic [$clog2(DEPTH)-1:0] fetch_addr,
    output logic                     fetch_strobe,
    output logic                     cyc_clk,
    output logic                     eop_pull,
    output logic                     pass_done,
    output logic                     align_err
);
    localparam int ALIGN_B = $clog2(PIPE);

    logic           phase_last;
    logic           pin_req;
    logic           wrap_now;
    restart_cause_t cause;

    seq_phase_gen #(.DIV(DIV)) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_first (fetch_strobe),
        .phase_last  (phase_last),
        .cyc_clk     (cyc_clk)
    );

    seq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (ext_rst_n),
        .req   (pin_req)
    );

    seq_decode #(
        .CTRL_W   (CTRL_W),
        .EOP_CODE (EOP_CODE),
        .ALIGN_B  (ALIGN_B)
    ) u_decode (
        .ctrl     (instr_ctrl),
        .addr_low (fetch_addr[ALIGN_B-1:0]),
        .pin_req  (pin_req),
        .cause    (cause)
    );

    seq_restart_fsm #(.PIPE(PIPE)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (phase_last),
        .cause    (cause),
        .wrap_now (wrap_now),
        .pull     (eop_pull),
        .err      (align_err)
    );

    seq_addr_ctr #(.DEPTH(DEPTH)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (phase_last),
        .wrap_req  (wrap_now),
        .addr      (fetch_addr),
        .pass_done (pass_done)
    );

endmodule

// File: rtl/prog_sequencer_chk.sv
module prog_sequencer_chk #(
    parameter int DEPTH = 192,
    parameter int PIPE  = 4,
    parameter int AW    = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] fetch_addr,
    input logic          fetch_strobe,
    input logic          cyc_clk,
    input logic          eop_pull,
    input logic          pass_done,
    input logic          align_err
);
    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_strobe |-> $stable(fetch_addr));

    // R2
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(fetch_addr) < DEPTH);

    // R3
    end_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_strobe && $past(fetch_addr) == AW'(DEPTH - 1)) |-> fetch_addr == '0);

    // R5
    pull_unaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eop_pull |-> (32'(fetch_addr) % PIPE) != 0);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |=> align_err);

    // R9
    cyc_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cyc_clk) |-> fetch_strobe);

    // R11
    pass_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> (fetch_strobe && fetch_addr == '0));

endmodule

bind prog_sequencer prog_sequencer_chk #(
    .DEPTH (DEPTH),
    .PIPE  (PIPE)
) u_prog_sequencer_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_addr   (fetch_addr),
    .fetch_strobe (fetch_strobe),
    .cyc_clk      (cyc_clk),
    .eop_pull     (eop_pull),
    .pass_done    (pass_done),
    .align_err    (align_err)
);

// File: tb/test_prog_sequencer.sv
`timescale 1ns/1ps
module test_prog_sequencer;
    localparam int DEPTH = 192;
    localparam int DIV   = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic [3:0] instr_ctrl;
    logic [7:0] fetch_addr;
    logic       fetch_strobe, cyc_clk, eop_pull, pass_done, align_err;

    int  eop_at = -1;
    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    // store model: restart code 4'hA at eop_at, other values 0..6 elsewhere
    assign instr_ctrl = (int'(fetch_addr) == eop_at) ? 4'hA : 4'(int'(fetch_addr) % 7);

    prog_sequencer i_prog_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_rst_n    (ext_rst_n),
        .instr_ctrl   (instr_ctrl),
        .fetch_addr   (fetch_addr),
        .fetch_strobe (fetch_strobe),
        .cyc_clk      (cyc_clk),
        .eop_pull     (eop_pull),
        .pass_done    (pass_done),
        .align_err    (align_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit look);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        if (look) begin
            check(fetch_addr == 0, "R1 addr", fetch_addr, 0);
            check(fetch_strobe == 1, "R1 strobe", fetch_strobe, 1);
            check({cyc_clk, eop_pull, pass_done, align_err} == 4'b0, "R1 flags",
                  {cyc_clk, eop_pull, pass_done, align_err}, 0);
        end
        rst_n = 1'b1;
    endtask

    task automatic next_strobe();
        do @(negedge clk); while (!fetch_strobe);
    endtask

    // restart code at aligned address a
    task automatic run_code(input int a);
        bit seq_ok = 1, pull_ok = 1, pd_ok = 1;
        int act = 0, exp = 0;
        eop_at = a;
        do_reset(0);
        for (int i = 1; i <= a + 3; i++) begin
            next_strobe();
            if (seq_ok && fetch_addr != i) begin seq_ok = 0; act = fetch_addr; exp = i; end
            if (eop_pull != (i > a)) pull_ok = 0;
            if (pass_done) pd_ok = 0;
        end
        check(seq_ok, "R4 drain sequence", act, exp);
        check(pull_ok, "R5 pull window", 0, 1);
        check(pd_ok, "R11 no early pass mark", 1, 0);
        next_strobe();
        check(fetch_addr == 0, "R4 return to zero", fetch_addr, 0);
        check(pass_done == 1 && eop_pull == 0, "R11 pass mark", pass_done, 1);
        check(align_err == 0, "R6 aligned code no error", align_err, 0);
        next_strobe();
        check(fetch_addr == 1 && pass_done == 0, "R3 single wrap", fetch_addr, 1);
        eop_at = -1;
    endtask

    initial begin
        int n, h;
        bit ok;
        int act;

        // R1 reset state
        do_reset(1);

        // R9 / R2 cycle shape
        n = 0; h = 0;
        do begin
            @(negedge clk);
            n++;
            if (cyc_clk) h++;
        end while (!fetch_strobe);
        check(n == DIV, "R2 cycle length", n, DIV);
        check(h == DIV / 2, "R9 high clocks", h, DIV / 2);
        check(cyc_clk == 0 && fetch_addr == 1, "R9 low at strobe", cyc_clk, 0);

        // R2 / R3 full natural pass
        ok = 1; act = 0;
        for (int i = 2; i < DEPTH; i++) begin
            next_strobe();
            if (ok && (fetch_addr != i || pass_done || eop_pull)) begin ok = 0; act = fetch_addr; end
        end
        check(ok, "R2 sequential advance", act, 0);
        next_strobe();
        check(fetch_addr == 0, "R3 end wrap", fetch_addr, 0);
        check(pass_done == 1, "R11 pass mark after end", pass_done, 1);
        next_strobe();
        check(fetch_addr == 1, "R3 after wrap", fetch_addr, 1);

        // R4 / R5 / R11 sweep over every aligned address
        for (int a = 0; a < DEPTH; a += 4) run_code(a);

        // R6 unaligned code
        eop_at = 5;
        do_reset(0);
        ok = 1; act = 0;
        for (int i = 1; i <= 12; i++) begin
            next_strobe();
            if (ok && (fetch_addr != i || eop_pull)) begin ok = 0; act = fetch_addr; end
        end
        check(ok, "R6 unaligned code ignored", act, 12);
        check(align_err == 1, "R6 error set", align_err, 1);
        next_strobe();
        check(align_err == 1, "R6 error sticky", align_err, 1);
        eop_at = -1;

        // R7 aligned pin request
        do_reset(0);
        while (fetch_addr != 8) next_strobe();
        ext_rst_n = 1'b0;
        next_strobe();
        ext_rst_n = 1'b1;
        ok = (fetch_addr == 9) && !eop_pull;
        next_strobe(); ok &= (fetch_addr == 10) && !eop_pull;
        next_strobe(); ok &= (fetch_addr == 11) && !eop_pull;
        check(ok, "R7 pin drain", fetch_addr, 11);
        next_strobe();
        check(fetch_addr == 0 && pass_done, "R7 pin return to zero", fetch_addr, 0);
        check(align_err == 0, "R7 no error", align_err, 0);

        // R8 unaligned pin request
        do_reset(0);
        while (fetch_addr != 6) next_strobe();
        ext_rst_n = 1'b0;
        next_strobe();
        ext_rst_n = 1'b1;
        ok = 1;
        for (int i = 7; i <= 12; i++) begin
            if (fetch_addr != i) ok = 0;
            next_strobe();
        end
        check(ok && fetch_addr == 13, "R8 unaligned pin ignored", fetch_addr, 13);
        check(align_err == 1, "R8 error set", align_err, 1);

        // R10 code and pin in the same aligned instruction
        eop_at = 12;
        do_reset(0);
        while (fetch_addr != 12) next_strobe();
        ext_rst_n = 1'b0;
        next_strobe();
        ext_rst_n = 1'b1;
        ok = (fetch_addr == 13) && eop_pull;
        next_strobe(); ok &= (fetch_addr == 14) && eop_pull;
        next_strobe(); ok &= (fetch_addr == 15) && eop_pull;
        check(ok, "R10 code takes precedence", eop_pull, 1);
        next_strobe();
        check(fetch_addr == 0 && !eop_pull, "R10 return to zero", fetch_addr, 0);
        eop_at = -1;

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule